// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block turns a six-bit operand specifier (a three-bit addressing mode and a three-bit register number) into a final operand location for a 16-bit machine with eight general registers. The result is either "the operand is register N" or "the operand is in memory at address A". Along the way the block reads the extension word that follows the instruction and the indirect pointer from memory. It also reports the single register update that auto-increment, auto-decrement and extension fetches cause. The top register is the program counter and the one below it is the stack pointer.

A specifier enters on a valid/ready handshake together with a byte/word flag and a snapshot of all register values. The block accepts a new specifier only while idle, so `spec_ready` low is the back-pressure. Memory reads use a request port: `mem_rd_valid` and `mem_rd_addr` stay steady until `mem_rd_ready`, and the data on `mem_rd_data` is taken in that same cycle. The result is offered on `res_valid` and all result fields are held until `res_ready`. The accepted result is the done event. The caller owns the register file and applies the write-back when it consumes the result.

Top module: `opnd_ea_seq`

## Requirements
- R1: Mode 0 reports a register operand (`res_is_reg`=1, `res_reg` = specifier register). It issues no memory read and requests no write-back.
- R2: Mode 1 reports a memory operand at the register's contents. It issues no read and requests no write-back.
- R3: Mode 2 reports the register's contents as address and writes back contents+step. Mode 4 reports contents−step and writes back that same value. The step is 2 for word operands. For byte operands it is 1, except for registers 6 and 7, which step by 2.
- R4: Modes 3 and 5 read a pointer word and report it as the address. Mode 3 reads at the register's contents and mode 5 reads at contents−2. The register is written back to contents+2 or contents−2, always stepping by 2 whatever the operand width.
- R5: Mode 6 reads the extension word at the PC (register 7) and writes back PC+2 to register 7. The address is the register plus the extension word. For register 7 the base is PC+2, which gives instruction address + 4 + extension when the PC points just past the opcode.
- R6: Mode 7 computes the mode 6 address, reads a pointer word there and reports that pointer as the address. With register 7, mode 2 gives an immediate operand at the PC and mode 3 gives an absolute address read at the PC. Both step the PC by 2.
- R7: The extension read always comes before the pointer read. Every read waits for `mem_rd_ready`, and its address is held steady until then.
- R8: A word operand with an odd final address sets `res_trap`. Any required read at an odd address is never issued; instead the block reports `res_trap` with that address. A trap suppresses `wb_en`. Byte operands at odd addresses do not trap.
- R9: `res_valid` and all result fields stay stable until `res_ready`. `spec_ready` is low whenever a specifier is in progress or a result is pending.
- R10: After reset `spec_ready`=1, `res_valid`=0 and `mem_rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_valid | input | 1 | Specifier offered |
| spec_ready | output | 1 | Block idle, specifier accepted |
| spec_mode | input | 3 | Addressing mode |
| spec_reg | input | 3 | Register number |
| spec_byte | input | 1 | 1 = byte operand, 0 = word |
| reg_file | input | 128 | Register values, register i at bits 16i+15:16i |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Read accepted, data valid this cycle |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_data | input | 16 | Read data |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result consumed |
| res_is_reg | output | 1 | Operand is a register |
| res_reg | output | 3 | Operand register number |
| res_addr | output | 16 | Operand memory address |
| res_trap | output | 1 | Odd-address trap |
| wb_en | output | 1 | Register write-back requested |
| wb_reg | output | 3 | Write-back register |
| wb_data | output | 16 | Write-back value |

## Verification
The bench builds the block with its default widths: 16-bit data and eight registers, so the byte-step exception starts at register 6. This covers all eight modes on ordinary registers and on the stack pointer and PC. It also reaches the byte step boundary between registers 5 and 6, and the program-counter forms (immediate, absolute, relative, relative indirect). Read-ready delays and result back-pressure of zero to several cycles test the hold rules. Odd register values and odd pointer data reach the trap at each of the three places a read or final address can be odd.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXT  = 2'd1,
    ST_PTR  = 2'd2,
    ST_DONE = 2'd3
  } ea_state_e;

  // mode[2:1] groups; mode[0] adds one level of indirection
  localparam logic [1:0] GRP_PLAIN = 2'd0;
  localparam logic [1:0] GRP_POSTI = 2'd1;
  localparam logic [1:0] GRP_PRED  = 2'd2;
  localparam logic [1:0] GRP_INDEX = 2'd3;
endpackage

// File: rtl/opnd_ea_step.sv
module opnd_ea_step #(
  parameter int DW         = 16,
  parameter int RW         = 3,
  parameter int WIDE_FIRST = 6
) (
  input  logic          byte_op,
  input  logic [RW-1:0] reg_idx,
  output logic [DW-1:0] step
);
  localparam logic [RW-1:0] WF = RW'(WIDE_FIRST);

  always_comb begin
    if (!byte_op || (reg_idx >= WF)) step = DW'(2);
    else                             step = DW'(1);
  end
endmodule

// File: rtl/opnd_ea_plan.sv
module opnd_ea_plan
  import opnd_ea_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int PC_IDX = 7
) (
  input  logic [2:0]    mode,
  input  logic [RW-1:0] reg_idx,
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] pc_val,
  input  logic [DW-1:0] step,
  output logic          is_reg,
  output logic          need_ext,
  output logic          need_ptr,
  output logic [DW-1:0] first_addr,
  output logic [DW-1:0] ext_base,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [DW-1:0] wb_data
);
  localparam logic [DW-1:0] TWO = DW'(2);
  localparam logic [RW-1:0] PCR = RW'(PC_IDX);

  logic [DW-1:0] eff_step;
  logic [DW-1:0] pre_dec;

  assign eff_step = mode[0] ? TWO : step;
  assign pre_dec  = reg_val - eff_step;

  always_comb begin
    is_reg     = 1'b0;
    need_ext   = 1'b0;
    need_ptr   = mode[0] && (mode[2:1] != GRP_PLAIN);
    first_addr = reg_val;
    ext_base   = reg_val;
    wb_en      = 1'b0;
    wb_reg     = reg_idx;
    wb_data    = reg_val;
    unique case (mode[2:1])
      GRP_PLAIN: begin
        is_reg = !mode[0];
      end
      GRP_POSTI: begin
        wb_en   = 1'b1;
        wb_data = reg_val + eff_step;
      end
      GRP_PRED: begin
        first_addr = pre_dec;
        wb_en      = 1'b1;
        wb_data    = pre_dec;
      end
      default: begin
        need_ext   = 1'b1;
        first_addr = pc_val;
        ext_base   = (reg_idx == PCR) ? (pc_val + TWO) : reg_val;
        wb_en      = 1'b1;
        wb_reg     = PCR;
        wb_data    = pc_val + TWO;
      end
    endcase
  end
endmodule

// File: rtl/opnd_ea_seq.sv
module opnd_ea_seq
  import opnd_ea_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spec_valid,
  output logic                 spec_ready,
  input  logic [2:0]           spec_mode,
  input  logic [$clog2(NREG)-1:0] spec_reg,
  input  logic                 spec_byte,
  input  logic [NREG*DW-1:0]   reg_file,
  output logic                 mem_rd_valid,
  input  logic                 mem_rd_ready,
  output logic [DW-1:0]        mem_rd_addr,
  input  logic [DW-1:0]        mem_rd_data,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic                 res_is_reg,
  output logic [$clog2(NREG)-1:0] res_reg,
  output logic [DW-1:0]        res_addr,
  output logic                 res_trap,
  output logic                 wb_en,
  output logic [$clog2(NREG)-1:0] wb_reg,
  output logic [DW-1:0]        wb_data
);
  localparam int RW     = $clog2(NREG);
  localparam int PC_IDX = NREG - 1;
  localparam int SP_IDX = NREG - 2;

  // unpack register snapshot
  logic [DW-1:0] regs [NREG];
  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign regs[g] = reg_file[g*DW +: DW];
  end

  logic [DW-1:0] sel_val;
  assign sel_val = regs[spec_reg];

  logic [DW-1:0] step;
  opnd_ea_step #(.DW(DW), .RW(RW), .WIDE_FIRST(SP_IDX)) u_step (
    .byte_op (spec_byte),
    .reg_idx (spec_reg),
    .step    (step)
  );

  logic          p_is_reg, p_need_ext, p_need_ptr, p_wb_en;
  logic [DW-1:0] p_first, p_base, p_wb_data;
  logic [RW-1:0] p_wb_reg;

  opnd_ea_plan #(.DW(DW), .RW(RW), .PC_IDX(PC_IDX)) u_plan (
    .mode       (spec_mode),
    .reg_idx    (spec_reg),
    .reg_val    (sel_val),
    .pc_val     (regs[PC_IDX]),
    .step       (step),
    .is_reg     (p_is_reg),
    .need_ext   (p_need_ext),
    .need_ptr   (p_need_ptr),
    .first_addr (p_first),
    .ext_base   (p_base),
    .wb_en      (p_wb_en),
    .wb_reg     (p_wb_reg),
    .wb_data    (p_wb_data)
  );

  ea_state_e     state;
  logic [DW-1:0] addr_q, base_q, wb_data_q;
  logic          need_ptr_q, byte_q, is_reg_q, wb_en_q, fetch_trap_q;
  logic [RW-1:0] reg_q, wb_reg_q;

  logic in_fetch;
  assign in_fetch = (state == ST_EXT) || (state == ST_PTR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      addr_q       <= '0;
      base_q       <= '0;
      wb_data_q    <= '0;
      need_ptr_q   <= 1'b0;
      byte_q       <= 1'b0;
      is_reg_q     <= 1'b0;
      wb_en_q      <= 1'b0;
      fetch_trap_q <= 1'b0;
      reg_q        <= '0;
      wb_reg_q     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (spec_valid) begin
            addr_q       <= p_first;
            base_q       <= p_base;
            need_ptr_q   <= p_need_ptr;
            byte_q       <= spec_byte;
            is_reg_q     <= p_is_reg;
            reg_q        <= spec_reg;
            wb_en_q      <= p_wb_en;
            wb_reg_q     <= p_wb_reg;
            wb_data_q    <= p_wb_data;
            fetch_trap_q <= 1'b0;
            if (p_need_ext)      state <= ST_EXT;
            else if (p_need_ptr) state <= ST_PTR;
            else                 state <= ST_DONE;
          end
        end
        ST_EXT: begin
          if (addr_q[0]) begin
            fetch_trap_q <= 1'b1;
            state        <= ST_DONE;
          end else if (mem_rd_ready) begin
            addr_q <= base_q + mem_rd_data;
            state  <= need_ptr_q ? ST_PTR : ST_DONE;
          end
        end
        ST_PTR: begin
          if (addr_q[0]) begin
            fetch_trap_q <= 1'b1;
            state        <= ST_DONE;
          end else if (mem_rd_ready) begin
            addr_q <= mem_rd_data;
            state  <= ST_DONE;
          end
        end
        default: begin
          if (res_ready) state <= ST_IDLE;
        end
      endcase
    end
  end

  assign spec_ready   = (state == ST_IDLE);
  assign mem_rd_valid = in_fetch && !addr_q[0];
  assign mem_rd_addr  = addr_q;

  assign res_valid  = (state == ST_DONE);
  assign res_is_reg = is_reg_q;
  assign res_reg    = reg_q;
  assign res_addr   = addr_q;
  assign res_trap   = fetch_trap_q || (!is_reg_q && !byte_q && addr_q[0]);
  assign wb_en      = wb_en_q && !res_trap;
  assign wb_reg     = wb_reg_q;
  assign wb_data    = wb_data_q;
endmodule

// File: rtl/opnd_ea_chk.sv
module opnd_ea_chk #(
  parameter int DW = 16,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spec_ready,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [DW-1:0] mem_rd_addr,
  input logic          res_valid,
  input logic          res_ready,
  input logic          res_is_reg,
  input logic [DW-1:0] res_addr,
  input logic          res_trap,
  input logic          wb_en,
  input logic [RW-1:0] wb_reg,
  input logic [DW-1:0] wb_data
);
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  assert_no_odd_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !mem_rd_addr[0]);

  assert_trap_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_trap |-> !wb_en);

  assert_res_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_trap)
      && $stable(wb_en) && $stable(wb_reg) && $stable(wb_data));

  assert_busy_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || mem_rd_valid) |-> !spec_ready);

  assert_reg_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_is_reg |-> !wb_en && !res_trap);

  assert_single_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && mem_rd_valid));
endmodule

bind opnd_ea_seq opnd_ea_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .spec_ready   (spec_ready),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_is_reg   (res_is_reg),
  .res_addr     (res_addr),
  .res_trap     (res_trap),
  .wb_en        (wb_en),
  .wb_reg       (wb_reg),
  .wb_data      (wb_data)
);

// File: tb/sim_opnd_ea_seq.sv
module sim_opnd_ea_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spec_valid = 1'b0;
  logic spec_ready;
  logic [2:0] spec_mode = '0;
  logic [2:0] spec_reg = '0;
  logic spec_byte = 1'b0;
  logic [NREG*DW-1:0] reg_file = '0;
  logic mem_rd_valid;
  logic mem_rd_ready = 1'b0;
  logic [DW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic res_is_reg;
  logic [2:0] res_reg;
  logic [DW-1:0] res_addr;
  logic res_trap;
  logic wb_en;
  logic [2:0] wb_reg;
  logic [DW-1:0] wb_data;

  int checks = 0;
  int fails = 0;
  bit odd_data = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_ea_seq #(.DW(DW), .NREG(NREG)) u0 (.*);

  function automatic logic [DW-1:0] mem_word(input logic [DW-1:0] a);
    logic [DW-1:0] v;
    v = ({a[7:0], a[15:8]} ^ 16'h2468) & 16'hFFFE;
    return v | DW'(odd_data);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [2:0] mode, input logic [2:0] rn,
                        input bit byte_op, input int rdly, input int hdly);
    logic [DW-1:0] r [NREG];
    logic [DW-1:0] pc, v, a, p, base;
    logic [DW-1:0] rd_list [$];
    bit e_isreg, e_trap, e_wb;
    logic [2:0] e_wbr;
    logic [DW-1:0] e_wbd, step;
    int idx, wait_n;
    bit got;
    for (int i = 0; i < NREG; i++) r[i] = reg_file[i*DW +: DW];
    pc = r[7]; v = r[rn];
    step = (byte_op && rn < 6) ? 16'd1 : 16'd2;
    e_isreg = 0; e_wb = 0; e_wbr = rn; e_wbd = '0; a = v;
    case (mode)
      3'd0: e_isreg = 1;
      3'd1: a = v;
      3'd2: begin a = v; e_wb = 1; e_wbd = v + step; end
      3'd3: begin rd_list.push_back(v); e_wb = 1; e_wbd = v + 2; end
      3'd4: begin a = v - step; e_wb = 1; e_wbd = a; end
      3'd5: begin p = v - 2; rd_list.push_back(p); e_wb = 1; e_wbd = p; end
      default: begin
        rd_list.push_back(pc);
        base = (rn == 7) ? pc + 2 : v;
        e_wb = 1; e_wbr = 7; e_wbd = pc + 2;
        if (mode == 3'd7) rd_list.push_back(base + mem_word(pc));
      end
    endcase
    // walk the reads: stop at the first odd one
    e_trap = 0;
    for (int k = 0; k < rd_list.size(); k++) begin
      if (rd_list[k][0]) begin
        e_trap = 1; a = rd_list[k];
        while (rd_list.size() > k) void'(rd_list.pop_back());
        break;
      end
      if (k == rd_list.size() - 1) begin
        if (mode[2:1] == 2'b11 && mode[0] == 0) a = base + mem_word(rd_list[k]);
        else a = mem_word(rd_list[k]);
      end
    end
    if (!e_trap && !e_isreg && !byte_op && a[0]) e_trap = 1;
    if (e_trap) e_wb = 0;

    @(negedge clk);
    check(spec_ready == 1'b1, "R9", "spec_ready idle", spec_ready, 1);
    spec_valid = 1; spec_mode = mode; spec_reg = rn; spec_byte = byte_op;
    @(negedge clk);
    spec_valid = 0;
    idx = 0; wait_n = 0; got = 0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (res_valid) begin got = 1; break; end
      if (mem_rd_valid) begin
        if (wait_n == 0) begin
          check(idx < rd_list.size() && mem_rd_addr == rd_list[idx], "R7", "read address",
                mem_rd_addr, (idx < rd_list.size()) ? rd_list[idx] : -1);
        end
        if (wait_n >= rdly) begin
          mem_rd_ready = 1; mem_rd_data = mem_word(mem_rd_addr);
          @(negedge clk);
          mem_rd_ready = 0; idx++; wait_n = 0;
          continue;
        end
        wait_n++;
      end
      @(negedge clk);
    end
    check(got, req, "result arrives", got, 1);
    check(idx == rd_list.size(), "R7", "read count", idx, rd_list.size());
    check(res_is_reg == e_isreg, req, "is_reg", res_is_reg, e_isreg);
    if (e_isreg) check(res_reg == rn, req, "reg", res_reg, rn);
    else check(res_addr == a, req, "address", res_addr, a);
    check(res_trap == e_trap, e_trap ? "R8" : req, "trap", res_trap, e_trap);
    check(wb_en == e_wb, req, "wb_en", wb_en, e_wb);
    if (e_wb) begin
      check(wb_reg == e_wbr, req, "wb_reg", wb_reg, e_wbr);
      check(wb_data == e_wbd, req, "wb_data", wb_data, e_wbd);
    end
    for (int h = 0; h < hdly; h++) begin
      @(negedge clk);
      check(res_valid && (e_isreg || res_addr == a) && wb_en == e_wb && !spec_ready,
            "R9", "hold under back-pressure", res_addr, a);
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    check(!res_valid && spec_ready, "R9", "released after ready", res_valid, 0);
  endtask

  task automatic set_regs(input logic [DW-1:0] base);
    for (int i = 0; i < NREG; i++) reg_file[i*DW +: DW] = base + DW'(i * 16'h0122);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(spec_ready == 1 && !res_valid && !mem_rd_valid, "R10", "reset state",
          {spec_ready, res_valid, mem_rd_valid}, 3'b100);
    rst_n = 1;
    set_regs(16'h1000);
    run_op("R1", 3'd0, 3'd3, 0, 0, 0);
    run_op("R2", 3'd1, 3'd2, 0, 0, 1);
    run_op("R3", 3'd2, 3'd1, 0, 0, 0);
    run_op("R3", 3'd2, 3'd5, 1, 0, 0);
    run_op("R3", 3'd2, 3'd6, 1, 0, 2);
    run_op("R3", 3'd4, 3'd4, 1, 0, 0);
    run_op("R3", 3'd4, 3'd7, 1, 0, 0);
    run_op("R3", 3'd4, 3'd0, 0, 0, 0);
    run_op("R4", 3'd3, 3'd2, 1, 2, 0);
    run_op("R4", 3'd5, 3'd3, 1, 0, 1);
    run_op("R5", 3'd6, 3'd1, 0, 1, 0);
    run_op("R5", 3'd6, 3'd7, 0, 3, 0);
    run_op("R6", 3'd7, 3'd7, 0, 1, 2);
    run_op("R6", 3'd7, 3'd4, 1, 0, 0);
    run_op("R6", 3'd2, 3'd7, 1, 0, 0);
    run_op("R6", 3'd3, 3'd7, 0, 2, 0);
    // odd addresses
    reg_file[2*DW +: DW] = 16'h2001;
    run_op("R8", 3'd1, 3'd2, 0, 0, 0);
    run_op("R2", 3'd1, 3'd2, 1, 0, 0);
    run_op("R8", 3'd3, 3'd2, 1, 0, 0);
    run_op("R8", 3'd2, 3'd2, 0, 0, 1);
    run_op("R8", 3'd7, 3'd2, 0, 1, 0);
    reg_file[7*DW +: DW] = 16'h3003;
    run_op("R8", 3'd6, 3'd1, 0, 0, 0);
    reg_file[7*DW +: DW] = 16'h3004;
    odd_data = 1;
    run_op("R8", 3'd3, 3'd4, 1, 1, 0);
    run_op("R8", 3'd7, 3'd7, 1, 0, 0);
    odd_data = 0;
    run_op("R3", 3'd2, 3'd2, 1, 0, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule